// File: doc/BRIEF.md
# Programmable Display Raster Timing Generator

This block turns a handful of packed configuration words into the raster timing of a display controller. Each cycle of the pixel clock it drives horizontal and vertical sync, a data-enable strobe and the x/y coordinate of the active pixel. When a plane pixel is presented during the active area it is passed through. When none is offered, a programmable background colour is sent instead. Outside the active area the colour output is black.

Software writes words through a plain address/data/strobe port. Each axis takes its whole timing from one 32-bit word with three packed fields. The active width and height share a second word. The timing words are held in a shadow copy. The counters use a working copy that follows the shadow continuously while the engine is stopped, and only at a frame boundary while it runs. The intended sequence is: stop the engine, reprogram it, start it again. Restarting always begins at the frame origin.

Register addresses: 0 control, 1 active size, 2 horizontal timing, 3 vertical timing, 4 sync polarity, 5 background colour.

Top module: `disp_tmg_top`

## Requirements
- R1: After reset the engine is stopped. While the engine is stopped, both counters are held at zero, de is low, pos_x and pos_y are 0, and each sync output sits at its inactive level.
- R2: The horizontal word (address 2) packs back porch in bits 31:22, sync width in bits 21:11 and front porch in bits 10:0, all in pixel clocks. Each line is sync, then back porch, then active pixels, then front porch, and its length is the sum of the four.
- R3: The vertical word (address 3) uses the same packing counted in lines. The line counter advances once per completed line and wraps after sync + back porch + active height + front porch lines.
- R4: The size word (address 1) holds active height in bits 26:16 and active width in bits 10:0.
- R5: de is high exactly when both axes are inside their active region. pos_x and pos_y give the zero-based pixel and line index inside the active area, and both are 0 whenever de is low.
- R6: Control bit 0 (address 0) starts (1) or stops (0) the engine. In the first cycle after it is set, the raster is at line 0, pixel 0, with both syncs asserted.
- R7: Polarity word bit 0 (hsync) and bit 1 (vsync): 0 means active-high, 1 means active-low. A change applies from the next cycle, including to the idle level while stopped.
- R8: The background word (address 5, bits 23:0) resets to 0x7F7F7F. rgb_out is pix_rgb when de and pix_valid are both high, the background colour when de is high and pix_valid is low, and 0 when de is low.
- R9: Writes to the size or timing words while the engine runs do not change the current frame. They apply from the next frame start. While the engine is stopped they apply at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pix_valid | input | 1 | A plane pixel is offered this cycle |
| pix_rgb | input | 24 | Offered plane pixel |
| hsync | output | 1 | Horizontal sync, polarity per R7 |
| vsync | output | 1 | Vertical sync, polarity per R7 |
| de | output | 1 | Active-area data enable |
| pos_x | output | 11 | Active pixel index |
| pos_y | output | 11 | Active line index |
| rgb_out | output | 24 | Output colour |

## Verification
The bench builds the block with the package defaults: 11-bit timing fields, a 13-bit counter and a 3-bit register address. The reset values of the timing words describe a 1024x768 raster.

A tiny programmed raster of 10 clocks by 7 lines brings several frame wraps, shadow-to-working copy transfers and restarts within a few hundred cycles. A separate 800-pixel line with porches of 86, 128 and 42 clocks exercises the full field packing, including the 10-bit back porch.

// File: rtl/disp_tmg_pkg.sv
`timescale 1ns/1ps
package disp_tmg_pkg;
    localparam int FLD_W  = 11;
    localparam int CNT_W  = FLD_W + 2;
    localparam int ADDR_W = 3;
    localparam int RGB_W  = 24;
    localparam int WORD_W = 32;
    localparam int BP_W   = WORD_W - 22;

    localparam logic [RGB_W-1:0] BG_DEFAULT = 24'h7F7F7F;

    typedef struct packed {
        logic [FLD_W-1:0] back;
        logic [FLD_W-1:0] sync;
        logic [FLD_W-1:0] front;
        logic [FLD_W-1:0] active;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t h;
        axis_cfg_t v;
    } tmg_cfg_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_SIZE = 3'd1,
        RA_HTIM = 3'd2,
        RA_VTIM = 3'd3,
        RA_POL  = 3'd4,
        RA_BG   = 3'd5
    } reg_addr_e;

    localparam tmg_cfg_t CFG_DEFAULT = '{
        h: '{back: 11'd160, sync: 11'd136, front: 11'd24, active: 11'd1024},
        v: '{back: 11'd29,  sync: 11'd6,   front: 11'd3,  active: 11'd768}
    };

    function automatic axis_cfg_t unpack_timing(input logic [WORD_W-1:0] w,
                                                 input logic [FLD_W-1:0] act);
        axis_cfg_t c;
        c.back   = FLD_W'(w[WORD_W-1:22]);
        c.sync   = w[21:11];
        c.front  = w[FLD_W-1:0];
        c.active = act;
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] axis_total(input axis_cfg_t c);
        return CNT_W'(c.sync) + CNT_W'(c.back) + CNT_W'(c.active) + CNT_W'(c.front);
    endfunction
endpackage

// File: rtl/disp_tmg_regs.sv
`timescale 1ns/1ps
module disp_tmg_regs
    import disp_tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frame_wrap,
    output logic              run,
    output logic [1:0]        pol_inv,
    output logic [RGB_W-1:0]  bg,
    output tmg_cfg_t          live
);
    tmg_cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            pol_inv <= '0;
            bg      <= BG_DEFAULT;
            shadow  <= CFG_DEFAULT;
            live    <= CFG_DEFAULT;
        end else begin
            if (wr_en) begin
                case (reg_addr_e'(wr_addr))
                    RA_CTRL: run <= wr_data[0];
                    RA_SIZE: begin
                        shadow.h.active <= wr_data[FLD_W-1:0];
                        shadow.v.active <= wr_data[16+FLD_W-1:16];
                    end
                    RA_HTIM: shadow.h <= unpack_timing(wr_data, shadow.h.active);
                    RA_VTIM: shadow.v <= unpack_timing(wr_data, shadow.v.active);
                    RA_POL:  pol_inv <= wr_data[1:0];
                    RA_BG:   bg <= wr_data[RGB_W-1:0];
                    default: ;
                endcase
            end
            // working copy follows the shadow while stopped or at frame start
            if (!run || frame_wrap) begin
                live <= shadow;
            end
        end
    end
endmodule

// File: rtl/disp_tmg_axis.sv
`timescale 1ns/1ps
module disp_tmg_axis
    import disp_tmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  axis_cfg_t        cfg,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             in_sync,
    output logic             in_act,
    output logic [FLD_W-1:0] pos
);
    logic [CNT_W-1:0] total, act_lo, act_hi, rel;
    logic             last;

    always_comb begin
        total   = axis_total(cfg);
        act_lo  = CNT_W'(cfg.sync) + CNT_W'(cfg.back);
        act_hi  = act_lo + CNT_W'(cfg.active);
        last    = (cnt + CNT_W'(1)) >= total;
        wrap    = run && step && last;
        in_sync = cnt < CNT_W'(cfg.sync);
        in_act  = (cnt >= act_lo) && (cnt < act_hi);
        rel     = cnt - act_lo;
        pos     = in_act ? rel[FLD_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/disp_tmg_top.sv
`timescale 1ns/1ps
module disp_tmg_top
    import disp_tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pix_valid,
    input  logic [RGB_W-1:0]  pix_rgb,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [FLD_W-1:0]  pos_x,
    output logic [FLD_W-1:0]  pos_y,
    output logic [RGB_W-1:0]  rgb_out
);
    localparam int N_AXES = 2;

    logic             ctl_en;
    logic [1:0]       pol_inv;
    logic [RGB_W-1:0] bg;
    tmg_cfg_t         live;
    logic             frame_wrap;

    logic [CNT_W-1:0] axis_cnt [N_AXES];
    logic [FLD_W-1:0] axis_pos [N_AXES];
    logic [N_AXES-1:0] axis_wrap, axis_sync, axis_act;
    logic [CNT_W-1:0] hcnt, vcnt;

    disp_tmg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_wrap (frame_wrap),
        .run        (ctl_en),
        .pol_inv    (pol_inv),
        .bg         (bg),
        .live       (live)
    );

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        disp_tmg_axis u_axis (
            .clk     (clk),
            .rst     (rst),
            .run     (ctl_en),
            .step    ((a == 0) ? 1'b1 : axis_wrap[0]),
            .cfg     ((a == 0) ? live.h : live.v),
            .cnt     (axis_cnt[a]),
            .wrap    (axis_wrap[a]),
            .in_sync (axis_sync[a]),
            .in_act  (axis_act[a]),
            .pos     (axis_pos[a])
        );
    end

    assign frame_wrap = axis_wrap[1];
    assign hcnt       = axis_cnt[0];
    assign vcnt       = axis_cnt[1];

    always_comb begin
        de      = ctl_en && axis_act[0] && axis_act[1];
        hsync   = (ctl_en && axis_sync[0]) ^ pol_inv[0];
        vsync   = (ctl_en && axis_sync[1]) ^ pol_inv[1];
        pos_x   = de ? axis_pos[0] : '0;
        pos_y   = de ? axis_pos[1] : '0;
        rgb_out = !de ? '0 : (pix_valid ? pix_rgb : bg);
    end
endmodule

// File: rtl/disp_tmg_chk.sv
`timescale 1ns/1ps
module disp_tmg_chk
    import disp_tmg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ctl_en,
    input logic [CNT_W-1:0] hcnt,
    input logic [CNT_W-1:0] vcnt,
    input logic             de,
    input logic [FLD_W-1:0] pos_x,
    input logic [FLD_W-1:0] pos_y,
    input logic [RGB_W-1:0] rgb_out,
    input tmg_cfg_t         live
);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> (hcnt == '0 && vcnt == '0));

    // R2
    pixel_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && $past(ctl_en) && hcnt != '0) |-> hcnt == $past(hcnt) + CNT_W'(1));

    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && $past(ctl_en) && hcnt != '0) |-> $stable(vcnt));

    // R5
    first_px_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(de) |-> pos_x == '0);

    // R5
    blank_pos_chk: assert property (@(posedge clk) disable iff (rst)
        !de |-> (pos_x == '0 && pos_y == '0));

    // R8
    blank_rgb_chk: assert property (@(posedge clk) disable iff (rst)
        !de |-> rgb_out == '0);

    // R9
    frame_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && $past(ctl_en) && !(hcnt == '0 && vcnt == '0)) |-> $stable(live));
endmodule

bind disp_tmg_top disp_tmg_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctl_en  (ctl_en),
    .hcnt    (hcnt),
    .vcnt    (vcnt),
    .de      (de),
    .pos_x   (pos_x),
    .pos_y   (pos_y),
    .rgb_out (rgb_out),
    .live    (live)
);

// File: tb/tb_disp_tmg_top.sv
`timescale 1ns/1ps
module tb_disp_tmg_top;
    import disp_tmg_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic              pix_valid;
    logic [RGB_W-1:0]  pix_rgb;
    logic              hsync, vsync, de;
    logic [FLD_W-1:0]  pos_x, pos_y;
    logic [RGB_W-1:0]  rgb_out;

    always #2.5 clk = ~clk;

    disp_tmg_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb), .hsync(hsync), .vsync(vsync),
        .de(de), .pos_x(pos_x), .pos_y(pos_y), .rgb_out(rgb_out)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model: index 0..3 = h sync/back/active/front, 4..7 = vertical
    int m_en, mh, mv, m_pol, m_bg;
    int cur [8];
    int pend [8];

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic compare(input string tag);
        bit hin, vin, ha, va, e_de, bad;
        int e_x, e_y, e_rgb;
        logic e_hs, e_vs;
        hin  = mh < cur[0];
        vin  = mv < cur[4];
        ha   = (mh >= cur[0] + cur[1]) && (mh < cur[0] + cur[1] + cur[2]);
        va   = (mv >= cur[4] + cur[5]) && (mv < cur[4] + cur[5] + cur[6]);
        e_de = m_en != 0 && ha && va;
        e_hs = ((m_en != 0) && hin) ^ m_pol[0];
        e_vs = ((m_en != 0) && vin) ^ m_pol[1];
        e_x  = e_de ? mh - cur[0] - cur[1] : 0;
        e_y  = e_de ? mv - cur[4] - cur[5] : 0;
        e_rgb = !e_de ? 0 : (pix_valid ? int'(pix_rgb) : m_bg);
        bad = 0;
        n_vec++;
        if (hsync !== e_hs) begin
            bad = 1; $display("FAIL %s R2/R7 hsync got %0b exp %0b", tag, hsync, e_hs);
        end
        if (vsync !== e_vs) begin
            bad = 1; $display("FAIL %s R3/R7 vsync got %0b exp %0b", tag, vsync, e_vs);
        end
        if (de !== e_de) begin
            bad = 1; $display("FAIL %s R5 de got %0b exp %0b", tag, de, e_de);
        end
        if (int'(pos_x) != e_x || int'(pos_y) != e_y) begin
            bad = 1; $display("FAIL %s R5 pos got %0d,%0d exp %0d,%0d", tag, pos_x, pos_y, e_x, e_y);
        end
        if (int'(rgb_out) != e_rgb) begin
            bad = 1; $display("FAIL %s R8 rgb got %06h exp %06h", tag, rgb_out, e_rgb);
        end
        if (bad) n_bad++;
    endtask

    task automatic model_step();
        int ht, vt;
        if (m_en == 0) begin
            mh = 0; mv = 0;
            for (int i = 0; i < 8; i++) cur[i] = pend[i];
        end else begin
            ht = cur[0] + cur[1] + cur[2] + cur[3];
            vt = cur[4] + cur[5] + cur[6] + cur[7];
            if (mh + 1 >= ht) begin
                mh = 0;
                if (mv + 1 >= vt) begin
                    mv = 0;
                    for (int i = 0; i < 8; i++) cur[i] = pend[i];
                end else mv++;
            end else mh++;
        end
    endtask

    task automatic model_write(input int a, input logic [31:0] d);
        case (a)
            0: m_en = d[0];
            1: begin pend[2] = d[10:0]; pend[6] = d[26:16]; end
            2: begin pend[1] = d[31:22]; pend[0] = d[21:11]; pend[3] = d[10:0]; end
            3: begin pend[5] = d[31:22]; pend[4] = d[21:11]; pend[7] = d[10:0]; end
            4: m_pol = d[1:0];
            5: m_bg = d[23:0];
            default: ;
        endcase
    endtask

    task automatic cyc(input bit we, input int a, input logic [31:0] d, input string tag);
        @(negedge clk);
        compare(tag);
        wr_en     = we;
        wr_addr   = ADDR_W'(a);
        wr_data   = d;
        pix_valid = (n_vec % 3) != 0;
        pix_rgb   = 24'hA50000 | 24'(n_vec);
        model_step();
        if (we) model_write(a, d);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        cyc(1, a, d, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 32'h0, tag);
    endtask

    function automatic logic [31:0] tword(input int bp, input int sw, input int fp);
        return (32'(bp) << 22) | (32'(sw) << 11) | 32'(fp);
    endfunction

    // R1: reset state, stopped engine
    task automatic t_reset();
        idle(6, "R1 reset idle");
    endtask

    // R2 R3 R4 R5 R6 R8: small raster, default background
    task automatic t_small();
        wr(1, (32'd3 << 16) | 32'd4, "R4 size");
        wr(2, tword(3, 2, 1), "R2 htim");
        wr(3, tword(2, 1, 1), "R3 vtim");
        idle(2, "R1 stopped after cfg");
        wr(0, 32'd1, "R6 start");
        idle(150, "R2 R3 R5 R8 small raster");
    endtask

    // R9: timing change while running lands at next frame; background change
    task automatic t_shadow();
        idle(13, "R9 pre");
        wr(2, tword(3, 2, 3), "R9 htim while running");
        wr(5, 32'h00123456, "R8 bg write");
        idle(170, "R9 across frame");
    endtask

    // R7: polarity while running and while stopped
    task automatic t_pol();
        wr(4, 32'd3, "R7 invert both");
        idle(40, "R7 inverted running");
        wr(0, 32'd0, "R1 stop");
        idle(6, "R7 idle level inverted");
        wr(4, 32'd1, "R7 hsync only");
        idle(3, "R7 idle level mixed");
        wr(4, 32'd0, "R7 restore");
    endtask

    // R6 R1: stop mid frame and restart at origin
    task automatic t_restart();
        wr(0, 32'd1, "R6 restart");
        idle(37, "R6 run part");
        wr(0, 32'd0, "R1 stop mid frame");
        idle(4, "R1 hold");
        wr(0, 32'd1, "R6 restart origin");
        idle(90, "R6 after restart");
        wr(0, 32'd0, "R1 stop");
    endtask

    // R2 R4: 800-wide line with packed 86/128/42 porches
    task automatic t_ref800();
        wr(1, (32'd2 << 16) | 32'd800, "R4 size 800");
        wr(2, tword(86, 128, 42), "R2 htim 800");
        wr(3, tword(1, 1, 1), "R3 vtim short");
        wr(0, 32'd1, "R6 start 800");
        idle(2300, "R2 800 line");
        wr(0, 32'd0, "R1 stop");
        idle(3, "R1 final idle");
    endtask

    initial begin
        rst = 1'b1; wr_en = 0; wr_addr = '0; wr_data = '0;
        pix_valid = 0; pix_rgb = '0;
        m_en = 0; mh = 0; mv = 0; m_pol = 0; m_bg = 32'h7F7F7F;
        pend = '{136, 160, 1024, 24, 6, 29, 768, 3};
        cur  = pend;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_small();
        t_shadow();
        t_pol();
        t_restart();
        t_ref800();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got running exp finished");
            summary();
            $finish;
        end
    end
endmodule